// File: doc/BRIEF.md
# Motion Vector Prediction and Motion Typing Sequencer

This block runs once per macroblock, before any block matching starts. A single start pulse captures two neighbourhoods of motion vectors and two thresholds. The first neighbourhood comes from the previous frame and holds eight neighbour vectors plus one reference vector. The second comes from the current frame and holds three already-coded neighbours. From these the block builds four search-centre candidates. It also measures how scattered the vectors are in each neighbourhood, and from that it labels the macroblock's motion as SIMPLE, CRITICAL or CHAOS. A later search stage uses the label to pick its pattern and range.

The block has exactly one componentwise median-of-three unit and one vector-distance unit. A step counter shares them across a fixed 13-step schedule:
- two median steps;
- eight distance steps that keep a running maximum for the previous-frame spread;
- three distance steps that build a running sum for the current-frame spread.

Both spreads live in one shared accumulator register. The result is registered and marked by a one-cycle done pulse, and it then holds until the next run completes.

Top module: `mvp_type_seq`

## Requirements
- R1: After reset, busy_o and done_o are low, type_o is 0 and cand_o is all zeros.
- R2: A start_i seen at a clock edge while busy_o is low is accepted, and busy_o is high from the next cycle. done_o is a one-cycle pulse that rises 13 clock edges after the accepting edge, with busy_o low in that cycle. start_i while busy_o is high is ignored and produces no extra done pulse.
- R3: Contexts and thresholds are captured at the accepting edge. Later changes on those inputs do not affect the run in progress.
- R4: cand_o carries four 16-bit slots, with slot k at bits [16k+15:16k]. In each slot, bits [15:8] hold x and bits [7:0] hold y, both as two's complement. Slot 0 is always the zero vector.
- R5: Slot 1 is the componentwise median of the three current-frame vectors. Current vector j sits at cur_ctx_i[16j+15:16j], in the same x/y layout.
- R6: Slot 2 equals previous-frame slot 8, the reference vector at prv_ctx_i[143:128]. Slot 3 is the componentwise median of previous-frame slots 5, 6 and 7.
- R7: Distance between two vectors is |dx|+|dy|. The previous-frame spread is the largest distance from slots 0..7 to slot 8. That context counts as coherent only when the spread is strictly less than th_prv_i.
- R8: The current-frame spread is the sum of the distances from the three current vectors to slot 1. That context counts as coherent only when the spread is strictly less than th_cur_i.
- R9: type_o is 0 (SIMPLE) when both contexts are coherent, 2 (CHAOS) when neither is, and 1 (CRITICAL) otherwise. The value 3 never appears.
- R10: type_o and cand_o change only in the cycle where done_o is high, and hold their values until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for one macroblock |
| prv_ctx_i | input | 144 | Nine previous-frame vectors; slot 8 is the reference |
| cur_ctx_i | input | 48 | Three current-frame neighbour vectors |
| th_prv_i | input | 10 | Coherence threshold for the previous-frame spread |
| th_cur_i | input | 10 | Coherence threshold for the current-frame spread |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle result strobe |
| type_o | output | 2 | Motion class: 0 SIMPLE, 1 CRITICAL, 2 CHAOS |
| cand_o | output | 64 | Four search-centre candidates |

## Verification
The bench drives the following stimulus patterns:
- All-zero contexts with threshold 1, where both spreads are zero and the result must be SIMPLE.
- Contexts built so that exactly one neighbourhood is scattered, once for each side, to show that the two coherence flags are kept apart and the mixed case gives CRITICAL.
- Thresholds set to exactly each computed spread and then to spread+1, to separate the strict "below" rule from "at or below".
- Negative and extreme signed components, to expose unsigned median or distance errors.
- A start pulse during a run, and inputs scrambled right after acceptance, to show that the inputs are captured at acceptance and that extra starts are ignored.
- Random contexts and thresholds, to cover the rest of the space.

// File: rtl/mvp_seq_pkg.sv
package mvp_seq_pkg;

  typedef enum logic [1:0] {
    MT_SIMPLE   = 2'd0,
    MT_CRITICAL = 2'd1,
    MT_CHAOS    = 2'd2
  } mtype_e;

  function automatic mtype_e classify(input logic coh_prv, input logic coh_cur);
    if (coh_prv && coh_cur)        return MT_SIMPLE;
    else if (!coh_prv && !coh_cur) return MT_CHAOS;
    else                           return MT_CRITICAL;
  endfunction

endpackage

// File: rtl/mvp_median3.sv
module mvp_median3 #(
  parameter int CW = 8
) (
  input  logic [2*CW-1:0] a_i,
  input  logic [2*CW-1:0] b_i,
  input  logic [2*CW-1:0] c_i,
  output logic [2*CW-1:0] m_o
);
  for (genvar g = 0; g < 2; g++) begin : g_comp
    logic signed [CW-1:0] a, b, c, lo, hi, cap, mid;
    assign a   = a_i[g*CW +: CW];
    assign b   = b_i[g*CW +: CW];
    assign c   = c_i[g*CW +: CW];
    assign lo  = (a < b) ? a : b;
    assign hi  = (a < b) ? b : a;
    assign cap = (hi < c) ? hi : c;
    assign mid = (lo > cap) ? lo : cap;
    assign m_o[g*CW +: CW] = mid;
  end
endmodule

// File: rtl/mvp_absdist.sv
module mvp_absdist #(
  parameter int CW = 8,
  parameter int DW = CW + 2
) (
  input  logic [2*CW-1:0] a_i,
  input  logic [2*CW-1:0] b_i,
  output logic [DW-1:0]   d_o
);
  logic [CW:0] mag [2];

  for (genvar g = 0; g < 2; g++) begin : g_comp
    logic signed [CW:0] diff;
    assign diff   = $signed({a_i[g*CW+CW-1], a_i[g*CW +: CW]})
                  - $signed({b_i[g*CW+CW-1], b_i[g*CW +: CW]});
    assign mag[g] = diff[CW] ? (CW+1)'(-diff) : diff;
  end

  assign d_o = DW'({1'b0, mag[0]}) + DW'({1'b0, mag[1]});
endmodule

// File: rtl/mvp_ctrl.sv
module mvp_ctrl #(
  parameter int LAST = 12,
  parameter int SBW  = $clog2(LAST + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           run_o,
  output logic [SBW-1:0] step_o,
  output logic           fin_o
);
  localparam logic [SBW-1:0] S_LAST = SBW'(LAST);

  logic           run_q;
  logic [SBW-1:0] step_q;
  logic           accept;

  assign accept = start_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      step_q <= '0;
    end else if (accept) begin
      run_q  <= 1'b1;
      step_q <= '0;
    end else if (run_q) begin
      if (step_q == S_LAST) begin
        run_q  <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign step_o = step_q;
  assign fin_o  = run_q && (step_q == S_LAST);

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> run_q && (step_q == '0));

  // R2
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= S_LAST);
endmodule

// File: rtl/mvp_type_seq.sv
module mvp_type_seq
  import mvp_seq_pkg::*;
#(
  parameter int CW    = 8,
  parameter int NPREV = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [(NPREV+1)*2*CW-1:0]  prv_ctx_i,
  input  logic [3*2*CW-1:0]          cur_ctx_i,
  input  logic [CW+1:0]              th_prv_i,
  input  logic [CW+1:0]              th_cur_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [1:0]                 type_o,
  output logic [4*2*CW-1:0]          cand_o
);
  localparam int VW   = 2 * CW;
  localparam int SW   = CW + 2;
  localparam int NCUR = 3;
  localparam int LAST = NPREV + 4;
  localparam int SBW  = $clog2(LAST + 1);
  localparam logic [SBW-1:0] S_MEDC = SBW'(0);
  localparam logic [SBW-1:0] S_MEDP = SBW'(1);
  localparam logic [SBW-1:0] S_P0   = SBW'(2);
  localparam logic [SBW-1:0] S_PEND = SBW'(NPREV + 1);
  localparam logic [SBW-1:0] S_CUR0 = SBW'(NPREV + 2);

  logic           run, fin;
  logic [SBW-1:0] step;

  mvp_ctrl #(.LAST(LAST), .SBW(SBW)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .run_o  (run),
    .step_o (step),
    .fin_o  (fin)
  );

  logic accept;
  assign accept = start_i && !run;

  // snapshot of contexts and thresholds
  logic [VW-1:0] prv_q [NPREV+1];
  logic [VW-1:0] cur_q [NCUR];
  logic [SW-1:0] th_prv_q, th_cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= NPREV; k++) prv_q[k] <= '0;
      for (int j = 0; j < NCUR; j++)   cur_q[j] <= '0;
      th_prv_q <= '0;
      th_cur_q <= '0;
    end else if (accept) begin
      for (int k = 0; k <= NPREV; k++) prv_q[k] <= prv_ctx_i[k*VW +: VW];
      for (int j = 0; j < NCUR; j++)   cur_q[j] <= cur_ctx_i[j*VW +: VW];
      th_prv_q <= th_prv_i;
      th_cur_q <= th_cur_i;
    end
  end

  // shared median unit
  logic [VW-1:0] med_a, med_b, med_c, med_r;
  always_comb begin
    if (step == S_MEDC) begin
      med_a = cur_q[0]; med_b = cur_q[1]; med_c = cur_q[2];
    end else begin
      med_a = prv_q[NPREV-3]; med_b = prv_q[NPREV-2]; med_c = prv_q[NPREV-1];
    end
  end

  mvp_median3 #(.CW(CW)) i_med (.a_i(med_a), .b_i(med_b), .c_i(med_c), .m_o(med_r));

  // shared distance unit
  logic [VW-1:0] cand1_q, cand3_q;
  logic [VW-1:0] dst_a, dst_b;
  logic [SW-1:0] dst_r;
  always_comb begin
    dst_a = cur_q[0];
    dst_b = cand1_q;
    for (int k = 0; k < NPREV; k++)
      if (step == SBW'(k + 2)) begin
        dst_a = prv_q[k];
        dst_b = prv_q[NPREV];
      end
    for (int j = 0; j < NCUR; j++)
      if (step == SBW'(NPREV + 2 + j)) dst_a = cur_q[j];
  end

  mvp_absdist #(.CW(CW), .DW(SW)) i_dist (.a_i(dst_a), .b_i(dst_b), .d_o(dst_r));

  // shared spread register: running max, then running sum
  logic [SW-1:0] acc_q, sum_cur;
  logic          coh_prv_q;
  assign sum_cur = acc_q + dst_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      coh_prv_q <= 1'b0;
      cand1_q   <= '0;
      cand3_q   <= '0;
    end else if (run) begin
      if (step == S_MEDC) cand1_q <= med_r;
      if (step == S_MEDP) cand3_q <= med_r;
      if (step == S_P0) begin
        acc_q <= dst_r;
      end else if (step > S_P0 && step <= S_PEND) begin
        if (dst_r > acc_q) acc_q <= dst_r;
      end else if (step == S_CUR0) begin
        coh_prv_q <= (acc_q < th_prv_q);
        acc_q     <= dst_r;
      end else if (step > S_CUR0) begin
        acc_q <= sum_cur;
      end
    end
  end

  // result registers
  mtype_e          type_q;
  logic            done_q;
  logic [4*VW-1:0] cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      type_q <= MT_SIMPLE;
      cand_q <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        type_q <= classify(coh_prv_q, sum_cur < th_cur_q);
        cand_q <= {cand3_q, prv_q[NPREV], cand1_q, {VW{1'b0}}};
      end
    end
  end

  assign busy_o = run;
  assign done_o = done_q;
  assign type_o = type_q;
  assign cand_o = cand_q;

  // R7
  prv_max_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && step > S_P0 && step <= S_PEND) |=> acc_q >= $past(acc_q));

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  legal_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_o != 2'd3);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(cand_o) && $stable(type_o)));
endmodule

// File: tb/test_mvp_type_seq.sv
module test_mvp_type_seq;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [143:0] prv_ctx_i = '0;
  logic [47:0]  cur_ctx_i = '0;
  logic [9:0]   th_prv_i = '0;
  logic [9:0]   th_cur_i = '0;
  logic         busy_o, done_o;
  logic [1:0]   type_o;
  logic [63:0]  cand_o;

  mvp_type_seq i_mvp_type_seq (
    .clk_i, .rst_ni, .start_i, .prv_ctx_i, .cur_ctx_i, .th_prv_i, .th_cur_i,
    .busy_o, .done_o, .type_o, .cand_o
  );

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit reported = 1'b0;

  typedef struct {
    logic [1:0]  ty;
    logic [63:0] cand;
    int          due;
  } exp_t;
  exp_t q[$];
  exp_t last_exp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  function automatic int comp(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  function automatic int med3(input int a, input int b, input int c);
    if ((a <= b && b <= c) || (c <= b && b <= a)) return b;
    if ((b <= a && a <= c) || (c <= a && a <= b)) return a;
    return c;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [15:0] vec(input int x, input int y);
    return {8'(x), 8'(y)};
  endfunction

  // reference model built from R4..R8
  task automatic model(input logic [143:0] p, input logic [47:0] c,
                       output int sp, output int sc, output logic [63:0] cand);
    int px[9], py[9], cx[3], cy[3], m1x, m1y, m3x, m3y, d;
    for (int k = 0; k < 9; k++) begin
      px[k] = comp(p[k*16+8 +: 8]);
      py[k] = comp(p[k*16 +: 8]);
    end
    for (int j = 0; j < 3; j++) begin
      cx[j] = comp(c[j*16+8 +: 8]);
      cy[j] = comp(c[j*16 +: 8]);
    end
    m1x = med3(cx[0], cx[1], cx[2]);
    m1y = med3(cy[0], cy[1], cy[2]);
    m3x = med3(px[5], px[6], px[7]);
    m3y = med3(py[5], py[6], py[7]);
    sp = 0;
    for (int k = 0; k < 8; k++) begin
      d = iabs(px[k] - px[8]) + iabs(py[k] - py[8]);
      if (d > sp) sp = d;
    end
    sc = 0;
    for (int j = 0; j < 3; j++) sc += iabs(cx[j] - m1x) + iabs(cy[j] - m1y);
    cand = {vec(m3x, m3y), p[128 +: 16], vec(m1x, m1y), 16'h0000};
  endtask

  function automatic logic [1:0] expect_type(input int sp, input int sc, input int tp, input int tc);
    bit cp, cc;
    cp = sp < tp;
    cc = sc < tc;
    if (cp && cc) return 2'd0;
    if (!cp && !cc) return 2'd2;
    return 2'd1;
  endfunction

  // driver: push expectation, start, scramble inputs after acceptance (R3)
  task automatic run_case(input logic [143:0] p, input logic [47:0] c,
                          input int tp, input int tc, input bit poke);
    exp_t e;
    int sp, sc;
    model(p, c, sp, sc, e.cand);
    e.ty = expect_type(sp, sc, tp, tc);
    @(negedge clk_i);
    prv_ctx_i = p; cur_ctx_i = c;
    th_prv_i = 10'(tp); th_cur_i = 10'(tc);
    start_i = 1'b1;
    e.due = cyc + 14;
    q.push_back(e);
    last_exp = e;
    @(negedge clk_i);
    start_i = 1'b0;
    prv_ctx_i = {$urandom, $urandom, $urandom, $urandom, $urandom};
    cur_ctx_i = {$urandom, $urandom};
    th_prv_i = 10'($urandom); th_cur_i = 10'($urandom);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1;   // ignored while busy (R2)
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected done", 64'(type_o), 64'hx);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.due, "R2 done latency", 64'(cyc), 64'(e.due));
        chk(!busy_o, "R2 busy low at done", 64'(busy_o), 64'h0);
        chk(type_o == e.ty, "R9 type (R7 R8 coherence)", 64'(type_o), 64'(e.ty));
        chk(cand_o[15:0] == e.cand[15:0], "R4 slot0 zero", 64'(cand_o[15:0]), 64'(e.cand[15:0]));
        chk(cand_o[31:16] == e.cand[31:16], "R5 slot1 median", 64'(cand_o[31:16]), 64'(e.cand[31:16]));
        chk(cand_o[63:32] == e.cand[63:32], "R6 slots 2 and 3 (R3 capture)",
            64'(cand_o[63:32]), 64'(e.cand[63:32]));
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    report();
    $finish;
  end

  initial begin
    logic [143:0] p;
    logic [47:0]  c;
    logic [63:0]  cd;
    int sp, sc;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(!busy_o && !done_o, "R1 idle after reset", {62'h0, busy_o, done_o}, 64'h0);
    chk(type_o == 2'd0, "R1 type reset", 64'(type_o), 64'h0);
    chk(cand_o == '0, "R1 cand reset", cand_o, 64'h0);

    // all zero, threshold 1 -> SIMPLE
    run_case('0, '0, 1, 1, 1'b0);
    // threshold 0 -> never coherent -> CHAOS
    run_case('0, '0, 0, 0, 1'b0);

    // prev coherent, current scattered -> CRITICAL
    p = '0;
    for (int k = 0; k < 9; k++) p[k*16 +: 16] = vec(3, -2);
    c = {vec(-100, 50), vec(20, -70), vec(90, 10)};
    run_case(p, c, 5, 10, 1'b0);
    // reverse
    p[3*16 +: 16] = vec(-120, 100);
    c = {vec(4, 4), vec(4, 4), vec(4, 4)};
    run_case(p, c, 5, 10, 1'b0);

    // extremes and negative medians
    for (int k = 0; k < 9; k++) p[k*16 +: 16] = vec((k % 2) ? 127 : -128, (k % 3) ? -128 : 127);
    c = {vec(127, -128), vec(-128, 127), vec(-1, -1)};
    run_case(p, c, 1023, 1023, 1'b0);

    // boundary: threshold equal to spread -> not coherent; spread+1 -> coherent
    for (int k = 0; k < 9; k++) p[k*16 +: 16] = vec(k * 5 - 20, 7 - k * 3);
    c = {vec(-9, 30), vec(12, -4), vec(0, 8)};
    model(p, c, sp, sc, cd);
    run_case(p, c, sp, sc, 1'b0);          // R7 R8 equality -> CHAOS
    run_case(p, c, sp + 1, sc + 1, 1'b0);  // -> SIMPLE
    run_case(p, c, sp, sc + 1, 1'b0);      // -> CRITICAL

    // extra start during run is ignored (R2), inputs scrambled (R3)
    c = {vec(-5, 6), vec(7, -8), vec(1, 2)};
    run_case(p, c, 50, 20, 1'b1);
    repeat (20) @(negedge clk_i);
    chk(q.size() == 0 && !busy_o, "R2 no run from ignored start", 64'(busy_o), 64'h0);
    // R10: outputs held
    chk(type_o == last_exp.ty, "R10 type held", 64'(type_o), 64'(last_exp.ty));
    chk(cand_o == last_exp.cand, "R10 cand held", cand_o, last_exp.cand);

    // random patterns
    for (int n = 0; n < 40; n++) begin
      p = {$urandom, $urandom, $urandom, $urandom, $urandom};
      c = {$urandom, $urandom};
      if (n % 2) begin
        for (int k = 0; k < 9; k++) p[k*16 +: 16] = p[k*16 +: 16] & 16'h0f0f;
      end
      run_case(p, c, int'($urandom % 600), int'($urandom % 600), n % 5 == 0);
    end

    report();
    $finish;
  end
endmodule